// File: doc/BRIEF.md
# Command/Response Byte-Port Status Machine

This block is the device side of a byte-wide command and response exchange. A host writes a command one byte at a time into a data port and watches a status byte and a 16-bit burst count to see how much room is left and whether more bytes are still wanted. The block reads the total command length from the header as the bytes arrive, so it knows which byte is the last one. Once the command is complete, the host sets the go flag. The block then hands the stored command to an execution engine and waits.

The engine reads the command bytes through an index port. It streams the response back as bytes with a valid strobe and marks the final byte. The host then reads the response from the same data port until the data-available flag drops. Writing the ready flag aborts whatever is in progress and clears both buffers. Only accesses tagged with the currently active locality have any effect.

Top module: `cmdrsp_port`

## Requirements
- R1: After reset the machine is idle: the status byte (offset 0x18) reads 0x80, the two burst-count bytes (offsets 0x19 low, 0x1A high) read 0, and the data port (offset 0x24) reads 0xFF.
- R2: A status write with bit 6 set moves the machine to ready from any state and discards any partial command or response. In ready the status reads 0xC0 and the burst count equals DEPTH.
- R3: Data-port writes in ready or reception store bytes in arrival order, and the machine enters reception. During reception the burst count equals DEPTH minus the number of stored bytes. In the execution state the engine sees byte i at index i and the stored count on `cmd_len`.
- R4: During reception, status bit 3 (expect) stays 1 until at least 6 bytes are stored and the stored count reaches the target length. It reads 0 immediately after the final byte is written. The target length is the big-endian value in bytes 2 to 5, raised to 10 if smaller and lowered to DEPTH if larger.
- R5: Data-port writes are ignored while expect is 0 or while the machine is idle, executing or complete.
- R6: A status write with bit 5 set while in reception with expect 0 enters execution. The status then reads bit 7 = 0, and `exec_start` pulses high for exactly one cycle.
- R7: A go write is ignored in idle, in ready, or while expect is 1.
- R8: In execution, bytes presented with `rsp_valid` are stored. The byte marked with `rsp_last` moves the machine to completion, where the status reads 0x90 while unread bytes remain, and the burst count equals the number of unread bytes.
- R9: Each data-port read in completion returns the next response byte in order. After the last one, status bit 4 reads 0 and the burst count reads 0. Further reads return 0xFF and have no effect.
- R10: An access whose locality differs from `act_loc` changes nothing and reads 0xFF.
- R11: Response bytes beyond DEPTH are dropped. The completion burst count never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_loc | input | LW | Locality currently granted |
| bus_valid | input | 1 | Host access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_loc | input | LW | Locality of the access |
| bus_addr | input | AW | Byte offset within the locality window |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte (combinational) |
| exec_start | output | 1 | One-cycle pulse on entering execution |
| cmd_len | output | CW | Number of stored command bytes |
| cmd_rd_idx | input | IW | Engine read index into the command buffer |
| cmd_rd_byte | output | 8 | Command byte at `cmd_rd_idx` |
| rsp_valid | input | 1 | Response byte strobe |
| rsp_byte | input | 8 | Response byte |
| rsp_last | input | 1 | Marks the final response byte |

## Verification
The bench builds the block with DEPTH = 16. With that depth, a header-size command of 10 bytes nearly fills the buffer, and a length field of 0x100 is lowered to the buffer size after only 16 writes. A 20-byte response also overruns the response buffer within a few cycles. This depth exercises both clamping directions of the length target, the overflow drop on the response side, and a buffer that fills completely, all in a short run.

// File: rtl/cmdrsp_pkg.sv
package cmdrsp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READY = 3'd1,
    ST_RECV  = 3'd2,
    ST_EXEC  = 3'd3,
    ST_DONE  = 3'd4
  } phase_t;

  localparam int HDR_BYTES  = 10;
  localparam int SIZE_FIRST = 2;
  localparam int SIZE_LAST  = 5;

  localparam int OFF_STATUS = 'h18;
  localparam int OFF_FIFO   = 'h24;

  localparam int B_VALID  = 7;
  localparam int B_RDY    = 6;
  localparam int B_GO     = 5;
  localparam int B_AVAIL  = 4;
  localparam int B_EXPECT = 3;
endpackage

// File: rtl/cmdrsp_cmd_buf.sv
module cmdrsp_cmd_buf
  import cmdrsp_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [7:0]    wr_byte,
  output logic [CW-1:0] count,
  output logic          expect_more,
  input  logic [IW-1:0] rd_idx,
  output logic [7:0]    rd_byte
);
  logic [7:0]    mem [DEPTH];
  logic [CW-1:0] count_q, count_d;
  logic [31:0]   size_q, size_d;
  logic [CW-1:0] target;
  logic          hdr_seen;
  logic          take;

  assign take = wr_en && !clr && (int'(count_q) < DEPTH);

  always_comb begin
    count_d = count_q;
    size_d  = size_q;
    if (clr) begin
      count_d = '0;
      size_d  = '0;
    end else if (take) begin
      count_d = count_q + CW'(1);
      if (count_q >= CW'(SIZE_FIRST) && count_q <= CW'(SIZE_LAST))
        size_d = {size_q[23:0], wr_byte};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      size_q  <= '0;
    end else begin
      count_q <= count_d;
      size_q  <= size_d;
    end
  end

  always_ff @(posedge clk) begin
    if (take) mem[count_q[IW-1:0]] <= wr_byte;
  end

  // length target: header size minimum, buffer size maximum
  always_comb begin
    if (size_q < 32'(HDR_BYTES))      target = CW'(HDR_BYTES);
    else if (size_q > 32'(DEPTH))     target = CW'(DEPTH);
    else                              target = CW'(size_q);
  end

  assign hdr_seen    = count_q > CW'(SIZE_LAST);
  assign expect_more = !hdr_seen || (count_q < target);
  assign count       = count_q;

  always_comb begin
    rd_byte = 8'h00;
    if (int'(rd_idx) < DEPTH) rd_byte = mem[rd_idx];
  end

  // R4: expect only drops as a result of a byte being written
  a_r4_expect_falls_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(expect_more) |-> $past(wr_en));
  // R3: the stored count never passes the buffer size
  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CW'(DEPTH));
  // R5: writes offered once expect is low do not move the count
  a_r5_no_take_when_done: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !expect_more && !clr) |=> $stable(count_q));
endmodule

// File: rtl/cmdrsp_rsp_buf.sv
module cmdrsp_rsp_buf #(
  parameter int DEPTH = 32,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [7:0]    push_byte,
  input  logic          pop,
  output logic [CW-1:0] unread,
  output logic [7:0]    head_byte
);
  logic [7:0]    mem [DEPTH];
  logic [CW-1:0] fill_q, fill_d;
  logic [CW-1:0] rd_q, rd_d;
  logic          do_push, do_pop;

  assign do_push = push && !clr && (int'(fill_q) < DEPTH);
  assign do_pop  = pop && !clr && (rd_q < fill_q);

  always_comb begin
    fill_d = fill_q;
    rd_d   = rd_q;
    if (clr) begin
      fill_d = '0;
      rd_d   = '0;
    end else begin
      if (do_push) fill_d = fill_q + CW'(1);
      if (do_pop)  rd_d   = rd_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= '0;
      rd_q   <= '0;
    end else begin
      fill_q <= fill_d;
      rd_q   <= rd_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[fill_q[IW-1:0]] <= push_byte;
  end

  always_comb begin
    head_byte = 8'hFF;
    if (int'(rd_q) < DEPTH) head_byte = mem[rd_q[IW-1:0]];
  end

  assign unread = fill_q - rd_q;

  // R9: the read pointer never overtakes the stored bytes
  a_r9_rd_le_fill: assert property (@(posedge clk) disable iff (!rst_n)
    rd_q <= fill_q);
  // R11: response storage is bounded by the buffer size
  a_r11_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= CW'(DEPTH));
endmodule

// File: rtl/cmdrsp_port.sv
module cmdrsp_port
  import cmdrsp_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int AW    = 12,
  parameter int LW    = 3,
  parameter int BW    = 16,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] act_loc,
  input  logic          bus_valid,
  input  logic          bus_write,
  input  logic [LW-1:0] bus_loc,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  output logic          exec_start,
  output logic [CW-1:0] cmd_len,
  input  logic [IW-1:0] cmd_rd_idx,
  output logic [7:0]    cmd_rd_byte,
  input  logic          rsp_valid,
  input  logic [7:0]    rsp_byte,
  input  logic          rsp_last
);
  // reset: asserted asynchronously, released through two flops
  logic rst_meta, rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_ni   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_ni   <= rst_meta;
    end
  end

  phase_t        state_q, state_d;
  logic          start_q, start_d;
  logic          loc_ok, hit;
  logic          sts_wr, fifo_wr, fifo_rd;
  logic          ready_wr, go_wr;
  logic          cmd_take, rsp_push, rsp_pop;
  logic          cmd_expect;
  logic [CW-1:0] cmd_count, rsp_unread;
  logic [7:0]    rsp_head;
  logic [7:0]    sts;
  logic [BW-1:0] burst;

  assign loc_ok   = (bus_loc == act_loc);
  assign hit      = bus_valid && loc_ok;
  assign sts_wr   = hit && bus_write && (bus_addr == AW'(OFF_STATUS));
  assign fifo_wr  = hit && bus_write && (bus_addr == AW'(OFF_FIFO));
  assign fifo_rd  = hit && !bus_write && (bus_addr == AW'(OFF_FIFO));
  assign ready_wr = sts_wr && bus_wdata[B_RDY];
  assign go_wr    = sts_wr && bus_wdata[B_GO] && !bus_wdata[B_RDY];

  assign cmd_take = fifo_wr && cmd_expect && !ready_wr &&
                    (state_q == ST_READY || state_q == ST_RECV);
  assign rsp_push = rsp_valid && (state_q == ST_EXEC) && !ready_wr;
  assign rsp_pop  = fifo_rd && (state_q == ST_DONE);

  cmdrsp_cmd_buf #(.DEPTH(DEPTH)) u_cmd (
    .clk         (clk),
    .rst_n       (rst_ni),
    .clr         (ready_wr),
    .wr_en       (cmd_take),
    .wr_byte     (bus_wdata),
    .count       (cmd_count),
    .expect_more (cmd_expect),
    .rd_idx      (cmd_rd_idx),
    .rd_byte     (cmd_rd_byte)
  );

  cmdrsp_rsp_buf #(.DEPTH(DEPTH)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_ni),
    .clr       (ready_wr),
    .push      (rsp_push),
    .push_byte (rsp_byte),
    .pop       (rsp_pop),
    .unread    (rsp_unread),
    .head_byte (rsp_head)
  );

  // next state
  always_comb begin
    state_d = state_q;
    if (ready_wr) begin
      state_d = ST_READY;
    end else begin
      unique case (state_q)
        ST_READY: if (cmd_take) state_d = ST_RECV;
        ST_RECV:  if (go_wr && !cmd_expect) state_d = ST_EXEC;
        ST_EXEC:  if (rsp_valid && rsp_last) state_d = ST_DONE;
        default:  state_d = state_q;
      endcase
    end
    start_d = (state_d == ST_EXEC) && (state_q != ST_EXEC);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= start_d;
    end
  end

  // status byte and burst count
  always_comb begin
    sts           = 8'h00;
    sts[B_VALID]  = (state_q != ST_EXEC);
    sts[B_RDY]    = (state_q == ST_READY);
    sts[B_AVAIL]  = (state_q == ST_DONE) && (rsp_unread != '0);
    sts[B_EXPECT] = (state_q == ST_RECV) && cmd_expect;
  end

  always_comb begin
    unique case (state_q)
      ST_READY, ST_RECV: burst = BW'(DEPTH) - BW'(cmd_count);
      ST_DONE:           burst = BW'(rsp_unread);
      default:           burst = '0;
    endcase
  end

  always_comb begin
    bus_rdata = 8'hFF;
    if (loc_ok) begin
      if (bus_addr == AW'(OFF_STATUS))            bus_rdata = sts;
      else if (bus_addr == AW'(OFF_STATUS + 1))   bus_rdata = burst[7:0];
      else if (bus_addr == AW'(OFF_STATUS + 2))   bus_rdata = burst[15:8];
      else if (bus_addr == AW'(OFF_FIFO))
        bus_rdata = sts[B_AVAIL] ? rsp_head : 8'hFF;
    end
  end

  assign exec_start = start_q;
  assign cmd_len    = cmd_count;

  // R6: execution is only entered through a go write with expect low
  a_r6_enter_exec: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(state_q == ST_EXEC) |-> $past(go_wr && !cmd_expect));
  // R6: the start pulse is one cycle wide
  a_r6_start_single: assert property (@(posedge clk) disable iff (!rst_ni)
    exec_start |=> !exec_start);
  // R8: completion follows a final response byte
  a_r8_done_on_last: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(state_q == ST_DONE) |-> $past(rsp_valid && rsp_last));
  // R10: foreign-locality accesses leave the phase alone
  a_r10_foreign_ignored: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_valid && !loc_ok && state_q != ST_EXEC) |=> $stable(state_q));
endmodule

// File: tb/cmdrsp_port_tb.sv
module cmdrsp_port_tb;
  localparam int DEPTH = 16;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = $clog2(DEPTH);
  localparam logic [2:0] ACT = 3'd2;
  localparam logic [2:0] OTHER = 3'd1;
  localparam logic [11:0] A_STS = 12'h018;
  localparam logic [11:0] A_BLO = 12'h019;
  localparam logic [11:0] A_BHI = 12'h01A;
  localparam logic [11:0] A_FIFO = 12'h024;

  logic clk, rst_n;
  logic bus_valid, bus_write;
  logic [2:0] bus_loc;
  logic [11:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic exec_start;
  logic [CW-1:0] cmd_len;
  logic [IW-1:0] cmd_rd_idx;
  logic [7:0] cmd_rd_byte;
  logic rsp_valid, rsp_last;
  logic [7:0] rsp_byte;

  cmdrsp_port #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .act_loc(ACT),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_loc(bus_loc),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .exec_start(exec_start), .cmd_len(cmd_len),
    .cmd_rd_idx(cmd_rd_idx), .cmd_rd_byte(cmd_rd_byte),
    .rsp_valid(rsp_valid), .rsp_byte(rsp_byte), .rsp_last(rsp_last)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  bit finished = 0;

  // behavioural reference model
  int st = 0;        // 0 idle, 1 ready, 2 recv, 3 exec, 4 done
  logic [7:0] cmdq[$];
  logic [7:0] rspq[$];
  int rdi = 0;
  bit m_start = 0;

  function automatic bit m_expect();
    longint unsigned l;
    int tgt;
    if (cmdq.size() < 6) return 1;
    l = {cmdq[2], cmdq[3], cmdq[4], cmdq[5]};
    if (l < 10) tgt = 10;
    else if (l > DEPTH) tgt = DEPTH;
    else tgt = int'(l);
    return cmdq.size() < tgt;
  endfunction

  function automatic int m_burst();
    if (st == 1 || st == 2) return DEPTH - cmdq.size();
    if (st == 4) return rspq.size() - rdi;
    return 0;
  endfunction

  function automatic logic [7:0] m_status();
    logic [7:0] s;
    s = 8'h00;
    s[7] = (st != 3);
    s[6] = (st == 1);
    s[4] = (st == 4) && (rdi < rspq.size());
    s[3] = (st == 2) && m_expect();
    return s;
  endfunction

  function automatic logic [7:0] m_rdata();
    int b;
    b = m_burst();
    if (bus_loc != ACT) return 8'hFF;
    case (bus_addr)
      A_STS:  return m_status();
      A_BLO:  return b[7:0];
      A_BHI:  return b[15:8];
      A_FIFO: return (st == 4 && rdi < rspq.size()) ? rspq[rdi] : 8'hFF;
      default: return 8'hFF;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      st = 0; cmdq.delete(); rspq.delete(); rdi = 0; m_start = 0;
    end else begin
      automatic bit acc  = bus_valid && (bus_loc == ACT);
      automatic bit stsw = acc && bus_write && bus_addr == A_STS;
      automatic bit fw   = acc && bus_write && bus_addr == A_FIFO;
      automatic bit fr   = acc && !bus_write && bus_addr == A_FIFO;
      automatic bit nstart = 0;
      if (stsw && bus_wdata[6]) begin
        st = 1; cmdq.delete(); rspq.delete(); rdi = 0;
      end else begin
        case (st)
          1, 2: begin
            if (fw && m_expect()) begin
              cmdq.push_back(bus_wdata); st = 2;
            end else if (st == 2 && stsw && bus_wdata[5] && !m_expect()) begin
              st = 3; nstart = 1;
            end
          end
          3: if (rsp_valid) begin
            if (rspq.size() < DEPTH) rspq.push_back(rsp_byte);
            if (rsp_last) st = 4;
          end
          4: if (fr && rdi < rspq.size()) rdi++;
          default: ;
        endcase
      end
      m_start = nstart;
    end
  end

  task automatic check8(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // compare against the model in the low phase of every clock
  always begin
    @(negedge clk);
    #2;
    if (rst_n && !finished) begin
      check8("R6", {7'd0, exec_start}, {7'd0, m_start});
      if (bus_valid && !bus_write) check8(cur_req, bus_rdata, m_rdata());
      if (st == 3) begin
        check8("R3", 8'(cmd_len), 8'(cmdq.size()));
        if (int'(cmd_rd_idx) < cmdq.size())
          check8("R3", cmd_rd_byte, cmdq[cmd_rd_idx]);
      end
    end
  end

  task automatic idle();
    @(negedge clk);
    bus_valid = 0; bus_write = 0; rsp_valid = 0; rsp_last = 0;
  endtask

  task automatic access(bit w, logic [11:0] a, logic [7:0] d, logic [2:0] l);
    @(negedge clk);
    bus_valid = 1; bus_write = w; bus_addr = a; bus_wdata = d; bus_loc = l;
    rsp_valid = 0; rsp_last = 0;
  endtask

  task automatic wr(logic [11:0] a, logic [7:0] d);
    access(1, a, d, ACT);
  endtask

  task automatic rd(logic [11:0] a);
    access(0, a, 8'h00, ACT);
  endtask

  task automatic send_cmd(int n, logic [31:0] lenf, int go_try_at);
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      b = (i >= 2 && i <= 5) ? lenf[8*(5-i) +: 8] : 8'(8'h40 + i);
      wr(A_FIFO, b);
      rd(A_STS);
      rd(A_BLO);
      if (i == go_try_at) begin
        cur_req = "R7";
        wr(A_STS, 8'h20);
        rd(A_STS);
        cur_req = "R4";
      end
    end
  endtask

  task automatic send_rsp(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bus_valid = 0; rsp_valid = 1; rsp_byte = 8'(8'hA0 + i); rsp_last = (i == n - 1);
    end
    idle();
  endtask

  task automatic drain(int n);
    for (int i = 0; i < n; i++) begin
      rd(A_FIFO);
      rd(A_BLO);
    end
    rd(A_STS);
  endtask

  task automatic peek_cmd(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bus_valid = 0; cmd_rd_idx = IW'(i);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 0; bus_valid = 0; bus_write = 0; bus_loc = ACT; bus_addr = '0;
    bus_wdata = '0; rsp_valid = 0; rsp_last = 0; rsp_byte = '0; cmd_rd_idx = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    repeat (4) idle();

    cur_req = "R1";
    rd(A_STS); rd(A_BLO); rd(A_BHI); rd(A_FIFO);

    cur_req = "R7";
    wr(A_STS, 8'h20); rd(A_STS);
    cur_req = "R5";
    wr(A_FIFO, 8'h11); rd(A_STS); rd(A_BLO);

    cur_req = "R2";
    wr(A_STS, 8'h40); rd(A_STS); rd(A_BLO); rd(A_BHI);
    cur_req = "R7";
    wr(A_STS, 8'h20); rd(A_STS);

    cur_req = "R4";
    send_cmd(12, 32'd12, 7);
    cur_req = "R5";
    wr(A_FIFO, 8'hEE); rd(A_BLO); rd(A_STS);

    cur_req = "R6";
    wr(A_STS, 8'h20); rd(A_STS); rd(A_BLO);
    peek_cmd(12);
    cur_req = "R5";
    wr(A_FIFO, 8'h77); idle();
    peek_cmd(13);

    cur_req = "R10";
    access(1, A_STS, 8'h40, OTHER);
    access(0, A_STS, 8'h00, OTHER);
    rd(A_STS);

    cur_req = "R8";
    send_rsp(11);
    rd(A_STS); rd(A_BLO); rd(A_BHI);
    cur_req = "R10";
    access(0, A_FIFO, 8'h00, OTHER);
    rd(A_BLO);
    cur_req = "R9";
    drain(11);
    rd(A_FIFO); rd(A_FIFO); rd(A_STS); rd(A_BLO);

    cur_req = "R2";
    wr(A_STS, 8'h40); rd(A_STS); rd(A_BLO);
    cur_req = "R4";
    send_cmd(10, 32'd5, -1);
    wr(A_FIFO, 8'h99); rd(A_BLO);
    cur_req = "R6";
    wr(A_STS, 8'h20); rd(A_STS);
    cur_req = "R11";
    send_rsp(20);
    rd(A_STS); rd(A_BLO); rd(A_BHI);
    drain(16);
    rd(A_FIFO);

    cur_req = "R2";
    wr(A_STS, 8'h40);
    send_cmd(4, 32'd12, -1);
    wr(A_STS, 8'h40); rd(A_STS); rd(A_BLO);
    cur_req = "R4";
    send_cmd(16, 32'h100, 9);
    wr(A_FIFO, 8'h55); rd(A_BLO);
    cur_req = "R6";
    wr(A_STS, 8'h20);
    peek_cmd(16);
    cur_req = "R2";
    wr(A_STS, 8'h40); rd(A_STS);
    send_rsp(3);
    rd(A_STS); rd(A_BLO); rd(A_FIFO);

    repeat (3) idle();
    if (!finished) begin
      finished = 1;
      summary();
      $finish;
    end
  end
endmodule